// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recent virtual-to-physical page mappings and translates a virtual address within the same cycle. Every stored entry is compared with the incoming virtual page number in parallel. On a match, the block forms the physical address by joining the stored physical page number to the untouched page offset. In the same cycle it checks the request against the entry's permissions and the requester's privilege level. When nothing matches, the block raises a miss. A page-table walker outside the block then fetches the mapping and installs it through the refill port.

Each entry stores a virtual page tag, a physical page number and five flags: valid, readable, writable, user-accessible and dirty. A new mapping is placed at the slot that a first-in first-out pointer selects. If the same virtual page is already present, the refill updates that entry in place. A flush input empties the whole array.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the replacement pointer starts at slot 0.
- R2: When `lk_valid` is high and a valid entry's tag equals `lk_vaddr[31:12]`, `lk_hit` is 1 in the same cycle. If the access is permitted, `lk_paddr` equals {entry physical page, `lk_vaddr[11:0]`}.
- R3: When `lk_valid` is high and no valid entry matches, `lk_miss` is 1, `lk_hit` is 0 and `lk_paddr` is 0.
- R4: A refill whose page is not present is written at the pointer slot. The pointer then advances by one and wraps from 31 to 0, so that after a full array the oldest installed entry is the one evicted.
- R5: A refill whose page equals a valid entry's tag overwrites that entry, and the pointer does not move. At most one valid entry ever matches a given page.
- R6: On a hit, `lk_fault` is 1 when any of these holds: a read (`lk_is_write`=0) goes to an entry that is not readable; a write goes to an entry that is not writable; or a user-mode access (`lk_user_mode`=1) goes to an entry that is not user-accessible. While `lk_fault` is 1, `lk_paddr` is 0.
- R7: `lk_dirty` shows the matched entry's dirty flag. A write hit that does not fault sets the flag from the next cycle on. A write that faults leaves the flag unchanged. A refill loads the flag from `rf_dirty`.
- R8: `flush` invalidates every entry from the next cycle on and returns the pointer to slot 0. If `flush` and a refill occur in the same cycle, the flush wins.
- R9: While `lk_valid` is 0, `lk_hit`, `lk_miss`, `lk_fault`, `lk_dirty` and `lk_paddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries and reset the pointer |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_is_write | input | 1 | 1 = store access, 0 = load access |
| lk_user_mode | input | 1 | 1 = requester runs in user mode |
| lk_hit | output | 1 | A valid entry matches the page |
| lk_miss | output | 1 | No entry matches; a walk is needed |
| lk_fault | output | 1 | Permission check failed on a hit |
| lk_dirty | output | 1 | Dirty flag of the matched entry |
| lk_paddr | output | 32 | Translated physical address |
| rf_valid | input | 1 | Install a mapping this cycle |
| rf_vpn | input | 20 | Virtual page of the new mapping |
| rf_ppn | input | 20 | Physical page of the new mapping |
| rf_can_read | input | 1 | Readable flag |
| rf_can_write | input | 1 | Writable flag |
| rf_user_ok | input | 1 | User-accessible flag |
| rf_dirty | input | 1 | Initial dirty flag |

## Verification
Several properties are checked on every cycle. No more than one valid entry ever matches a page. A permitted hit keeps the page offset intact. A fault occurs only together with a hit. A cycle after a flush produces no hit. An idle request drives all outputs low. A permitted write is followed on the same page by a dirty hit.

Other behaviours need the bench's scenarios because they appear only over many refills:
- eviction order across a full wrap of the pointer;
- in-place update of a page that is already present, with the pointer held;
- the pointer returning to slot 0 after a flush;
- the complete permission truth table.

// File: rtl/xlate_pkg.sv
// Shared types of the translation cache.
// Assumes: one flag set per entry, stored alongside tag and frame number.
package xlate_pkg;

    typedef struct packed {
        logic rd;     // loads allowed
        logic wr;     // stores allowed
        logic usr;    // user mode may access
        logic dirty;  // page has been written
    } pte_flags_t;

endpackage

// File: rtl/xlate_fifo_ptr.sv
// Replacement pointer: selects the next slot to overwrite, in round-robin order.
// Assumes: clear has priority over advance; ENTRIES >= 2.
module xlate_fifo_ptr #(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Step the pointer by one with wrap; return to zero on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/xlate_perm_chk.sv
// Permission check for one matched entry against the access kind and mode.
// Assumes: the caller qualifies the result with the hit.
module xlate_perm_chk
    import xlate_pkg::*;
(
    input  pte_flags_t flags,
    input  logic       is_write,
    input  logic       user_mode,
    output logic       denied
);

    // Deny on a missing read/write right or on user access to a kernel page.
    always_comb begin
        denied = (is_write ? !flags.wr : !flags.rd) || (user_mode && !flags.usr);
    end

endmodule

// File: rtl/xlate_entry_array.sv
// Entry storage with two parallel tag comparators (lookup and refill).
// Assumes: at most one valid entry per tag (the top keeps this invariant),
// so the index encoders need no priority order.
module xlate_entry_array
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  pte_flags_t         wr_flags,
    input  logic               dset_en,
    input  logic [IDX_W-1:0]   dset_idx,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic [ENTRIES-1:0] lk_match,
    output logic [IDX_W-1:0]   lk_idx,
    output logic [PPN_W-1:0]   lk_ppn,
    output pte_flags_t         lk_flags,
    input  logic [VPN_W-1:0]   rf_vpn,
    output logic               rf_found,
    output logic [IDX_W-1:0]   rf_idx
);

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q   [ENTRIES];
    logic [PPN_W-1:0]   ppn_q   [ENTRIES];
    pte_flags_t         flags_q [ENTRIES];
    logic [ENTRIES-1:0] rf_match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

        // Update one entry: reset, flush, refill write, or dirty set, in that priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                vpn_q[i]   <= '0;
                ppn_q[i]   <= '0;
                flags_q[i] <= '0;
            end else if (flush) begin
                valid_q[i] <= 1'b0;
            end else if (wr_en && wr_idx == MY_IDX) begin
                valid_q[i] <= 1'b1;
                vpn_q[i]   <= wr_vpn;
                ppn_q[i]   <= wr_ppn;
                flags_q[i] <= wr_flags;
            end else if (dset_en && dset_idx == MY_IDX) begin
                flags_q[i].dirty <= 1'b1;
            end
        end

        // Compare this entry's tag against the lookup and refill pages.
        always_comb begin
            lk_match[i] = valid_q[i] && (vpn_q[i] == lk_vpn);
            rf_match[i] = valid_q[i] && (vpn_q[i] == rf_vpn);
        end
    end

    // Encode the single lookup match and select its payload.
    always_comb begin
        lk_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_idx = IDX_W'(i);
        end
        lk_ppn   = ppn_q[lk_idx];
        lk_flags = flags_q[lk_idx];
    end

    // Encode the refill match, if the page is already present.
    always_comb begin
        rf_found = |rf_match;
        rf_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rf_match[i]) rf_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlate_cache.sv
// Fully associative translation cache: single-cycle lookup with permission
// check, refill port with round-robin victim choice, and whole-array flush.
// Assumes: the walker drives refills only for pages it has resolved; the
// lookup outputs are combinational from the request and the stored state.
module xlate_cache
    import xlate_pkg::*;
#(
    parameter int ENTRIES   = 32,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PPN_W    = PA_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_is_write,
    input  logic             lk_user_mode,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic             lk_dirty,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_can_read,
    input  logic             rf_can_write,
    input  logic             rf_user_ok,
    input  logic             rf_dirty
);

    logic [VPN_W-1:0]     lk_vpn;
    logic [PAGE_BITS-1:0] lk_off;
    logic [ENTRIES-1:0]   lk_match;
    logic [IDX_W-1:0]     lk_idx;
    logic [PPN_W-1:0]     lk_ppn;
    pte_flags_t           lk_flags;
    logic                 denied;
    logic                 rf_found;
    logic [IDX_W-1:0]     rf_idx;
    logic [IDX_W-1:0]     ptr;
    logic                 wr_en;
    logic [IDX_W-1:0]     wr_idx;
    pte_flags_t           wr_flags;
    logic                 dset_en;

    // Split the request address into page number and offset.
    always_comb begin
        lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
        lk_off = lk_vaddr[PAGE_BITS-1:0];
    end

    xlate_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_vpn   (rf_vpn),
        .wr_ppn   (rf_ppn),
        .wr_flags (wr_flags),
        .dset_en  (dset_en),
        .dset_idx (lk_idx),
        .lk_vpn   (lk_vpn),
        .lk_match (lk_match),
        .lk_idx   (lk_idx),
        .lk_ppn   (lk_ppn),
        .lk_flags (lk_flags),
        .rf_vpn   (rf_vpn),
        .rf_found (rf_found),
        .rf_idx   (rf_idx)
    );

    xlate_perm_chk u_perm (
        .flags     (lk_flags),
        .is_write  (lk_is_write),
        .user_mode (lk_user_mode),
        .denied    (denied)
    );

    xlate_fifo_ptr #(
        .ENTRIES (ENTRIES)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (flush),
        .advance (wr_en && !rf_found),
        .ptr     (ptr)
    );

    // Form the lookup results from the match and the permission check.
    always_comb begin
        lk_hit   = lk_valid && (|lk_match);
        lk_miss  = lk_valid && !(|lk_match);
        lk_fault = lk_hit && denied;
        lk_dirty = lk_hit && lk_flags.dirty;
        lk_paddr = (lk_hit && !denied) ? {lk_ppn, lk_off} : '0;
    end

    // Mark the page dirty on a permitted store to a clean entry.
    always_comb begin
        dset_en = lk_hit && !denied && lk_is_write && !lk_flags.dirty;
    end

    // Choose the refill slot: the existing copy of the page, or the pointer slot.
    always_comb begin
        wr_en          = rf_valid && !flush;
        wr_idx         = rf_found ? rf_idx : ptr;
        wr_flags.rd    = rf_can_read;
        wr_flags.wr    = rf_can_write;
        wr_flags.usr   = rf_user_ok;
        wr_flags.dirty = rf_dirty;
    end

endmodule

// File: rtl/xlate_cache_chk.sv
// Property checker for the translation cache, bound into every instance.
// Assumes: it observes ports and the per-entry match vector only.
module xlate_cache_chk #(
    parameter int ENTRIES   = 32,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               rf_valid,
    input logic               lk_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               lk_is_write,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic               lk_fault,
    input logic               lk_dirty,
    input logic [PA_W-1:0]    lk_paddr,
    input logic [ENTRIES-1:0] lk_match
);

    // R5: the refill rule keeps page tags unique among valid entries.
    assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R2: a permitted hit passes the page offset through unchanged.
    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !lk_fault) |-> (lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]));

    // R3: a miss never carries an address or a hit.
    assert_miss_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (!lk_hit && lk_paddr == '0));

    // R6: faults only on hits, and a faulting access gets no address.
    assert_fault_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_hit && lk_paddr == '0));

    // R8: the cycle after a flush nothing is found.
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> !lk_hit);

    // R9: an idle request drives every result low.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss && !lk_fault && !lk_dirty && lk_paddr == '0));

    // R7: a permitted store leaves the page marked dirty on the next lookup.
    assert_dirty_after_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lk_valid && lk_hit && !lk_fault && lk_is_write) && $past(!flush && !rf_valid)
         && lk_valid && lk_vaddr[VA_W-1:PAGE_BITS] == $past(lk_vaddr[VA_W-1:PAGE_BITS]))
        |-> (lk_hit && lk_dirty));

endmodule

bind xlate_cache xlate_cache_chk #(
    .ENTRIES   (ENTRIES),
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .rf_valid    (rf_valid),
    .lk_valid    (lk_valid),
    .lk_vaddr    (lk_vaddr),
    .lk_is_write (lk_is_write),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .lk_fault    (lk_fault),
    .lk_dirty    (lk_dirty),
    .lk_paddr    (lk_paddr),
    .lk_match    (lk_match)
);

// File: tb/tb_xlate_cache.sv
// Self-checking bench: fills, wraps and flushes the array, sweeps permissions.
module tb_xlate_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_is_write = 1'b0;
    logic        lk_user_mode = 1'b0;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty;
    logic [31:0] lk_paddr;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [19:0] rf_ppn = '0;
    logic        rf_can_read = 1'b0;
    logic        rf_can_write = 1'b0;
    logic        rf_user_ok = 1'b0;
    logic        rf_dirty = 1'b0;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    xlate_cache dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_is_write(lk_is_write),
        .lk_user_mode(lk_user_mode), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_fault(lk_fault), .lk_dirty(lk_dirty), .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
        .rf_can_read(rf_can_read), .rf_can_write(rf_can_write),
        .rf_user_ok(rf_user_ok), .rf_dirty(rf_dirty)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [19:0] vpn, input logic [11:0] off, input logic wr, input logic usr);
        @(negedge clk);
        rf_valid = 1'b0; flush = 1'b0;
        lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_is_write = wr; lk_user_mode = usr;
        #1;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [3:0] f);
        @(negedge clk);
        lk_valid = 1'b0; lk_is_write = 1'b0;
        rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn;
        rf_can_read = f[0]; rf_can_write = f[1]; rf_user_ok = f[2]; rf_dirty = f[3];
        @(posedge clk); #1;
        rf_valid = 1'b0;
    endtask

    task automatic expect_hit(input logic [19:0] vpn, input logic [19:0] ppn, input logic [11:0] off, input string tag);
        lookup(vpn, off, 1'b0, 1'b0);
        chk(lk_hit === 1'b1 && lk_miss === 1'b0 && lk_paddr === {ppn, off}, tag, lk_paddr, {ppn, off});
    endtask

    task automatic expect_miss(input logic [19:0] vpn, input string tag);
        lookup(vpn, 12'h0a4, 1'b0, 1'b0);
        chk(lk_miss === 1'b1 && lk_hit === 1'b0 && lk_paddr === 32'h0, tag,
            {30'h0, lk_hit, lk_miss}, 32'h1);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset
        expect_miss(20'h00100, "R1 reset empty");
        expect_miss(20'h00000, "R1 reset empty page 0");

        // R9: idle request gives quiet outputs
        @(negedge clk); lk_valid = 1'b0; #1;
        chk({lk_hit, lk_miss, lk_fault, lk_dirty} === 4'b0 && lk_paddr === 32'h0, "R9 idle",
            {28'h0, lk_hit, lk_miss, lk_fault, lk_dirty}, 32'h0);

        // R2/R4: fill all 32 slots, then look each up
        for (int i = 0; i < 32; i++) refill(20'h00100 + 20'(i), 20'h80000 + 20'(i * 3), 4'b0111);
        for (int i = 0; i < 32; i++)
            expect_hit(20'h00100 + 20'(i), 20'h80000 + 20'(i * 3), 12'((i * 37 + 5) & 12'hfff), "R2 full-array hit");
        expect_miss(20'h00200, "R3 absent page");

        // R4: wrap evicts the oldest slots in order
        refill(20'h00300, 20'h0a300, 4'b0111);
        refill(20'h00301, 20'h0a301, 4'b0111);
        expect_miss(20'h00100, "R4 oldest evicted");
        expect_miss(20'h00101, "R4 second evicted");
        expect_hit(20'h00300, 20'h0a300, 12'h123, "R4 new entry");

        // R5: refill of a present page updates in place, pointer held
        refill(20'h00105, 20'h07777, 4'b0111);
        expect_hit(20'h00105, 20'h07777, 12'hfff, "R5 in-place update");
        refill(20'h00302, 20'h0a302, 4'b0111);
        expect_miss(20'h00102, "R5 pointer unchanged, slot 2 evicted");
        expect_hit(20'h00103, 20'h80009, 12'h000, "R5 slot 3 kept");

        // R6: full permission sweep; flag bits f[0]=read f[1]=write f[2]=user
        for (int p = 0; p < 8; p++) refill(20'h00400 + 20'(p), 20'h0b400 + 20'(p), {1'b0, 3'(p)});
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 4; m++) begin
                logic wr, usr, exp_f;
                wr = m[0]; usr = m[1];
                exp_f = (wr ? !p[1] : !p[0]) || (usr && !p[2]);
                lookup(20'h00400 + 20'(p), 12'h0c8, wr, usr);
                chk(lk_hit === 1'b1 && lk_fault === exp_f &&
                    lk_paddr === (exp_f ? 32'h0 : {20'h0b400 + 20'(p), 12'h0c8}),
                    "R6 permission sweep", {31'h0, lk_fault}, {31'h0, exp_f});
            end
        end

        // R7: dirty tracking
        refill(20'h00600, 20'h0c600, 4'b0111);
        refill(20'h00601, 20'h0c601, 4'b0101);
        refill(20'h00602, 20'h0c602, 4'b1111);
        lookup(20'h00600, 12'h010, 1'b0, 1'b0);
        chk(lk_dirty === 1'b0, "R7 clean before store", {31'h0, lk_dirty}, 32'h0);
        lookup(20'h00600, 12'h010, 1'b1, 1'b0);
        chk(lk_hit === 1'b1 && lk_fault === 1'b0, "R7 permitted store", {31'h0, lk_fault}, 32'h0);
        lookup(20'h00600, 12'h010, 1'b0, 1'b0);
        chk(lk_dirty === 1'b1, "R7 dirty after store", {31'h0, lk_dirty}, 32'h1);
        lookup(20'h00601, 12'h010, 1'b1, 1'b0);
        chk(lk_fault === 1'b1, "R7 store to read-only faults", {31'h0, lk_fault}, 32'h1);
        lookup(20'h00601, 12'h010, 1'b0, 1'b0);
        chk(lk_dirty === 1'b0, "R7 faulting store leaves clean", {31'h0, lk_dirty}, 32'h0);
        lookup(20'h00602, 12'h010, 1'b0, 1'b0);
        chk(lk_dirty === 1'b1, "R7 refill loads dirty", {31'h0, lk_dirty}, 32'h1);

        // R8: flush empties, and beats a same-cycle refill
        @(negedge clk);
        lk_valid = 1'b0; flush = 1'b1; rf_valid = 1'b1; rf_vpn = 20'h006aa; rf_ppn = 20'h0d6aa;
        rf_can_read = 1'b1; rf_can_write = 1'b1; rf_user_ok = 1'b1; rf_dirty = 1'b0;
        @(negedge clk); flush = 1'b0; rf_valid = 1'b0;
        expect_miss(20'h00600, "R8 flushed entry");
        expect_miss(20'h00300, "R8 flushed entry 2");
        expect_miss(20'h006aa, "R8 flush beats refill");

        // R8/R4: pointer back at slot 0 -> 33rd refill evicts first post-flush entry
        for (int i = 0; i < 32; i++) refill(20'h00700 + 20'(i), 20'h0e700 + 20'(i), 4'b0111);
        refill(20'h007ff, 20'h0e7ff, 4'b0111);
        expect_miss(20'h00700, "R8 pointer reset, slot 0 evicted");
        expect_hit(20'h00701, 20'h0e701, 12'h456, "R8 slot 1 kept");
        expect_hit(20'h0071f, 20'h0e71f, 12'h789, "R4 last slot kept");
        expect_hit(20'h007ff, 20'h0e7ff, 12'habc, "R4 wrapped refill");

        @(negedge clk); lk_valid = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule